// File: doc/BRIEF.md
# Leading-Power Shift-and-Repeat-Add Multiplier

This block multiplies two unsigned 5-bit numbers over several clock cycles. When a start pulse is taken, it finds the highest set bit of the multiplier. That bit position is the exponent k, so 2^k is the largest power of two not above the multiplier. The block then doubles the multiplicand k times, one left shift per cycle. The part of the multiplier below the leading one is the remainder r = multiplier − 2^k. In a second phase the block adds the multiplicand onto the shifted value r times, one addition per cycle.

A Moore state machine sequences the two phases. One shared down-counter counts the shifts and then the additions. The 10-bit product is loaded into an output register in the same cycle that the done flag is raised for exactly one cycle. The product then holds until the next result. Operand widths are parameters; the product width is derived as twice the operand width.

Top module: `pow2_shift_add_mul`

## Requirements
- R1: When done is high, the product output equals multiplicand × multiplier, taken as unsigned values from the cycle in which start was accepted.
- R2: The shift phase lasts k cycles, where k is the bit index of the multiplier's most significant set bit. Each cycle doubles the running value once.
- R3: The add phase lasts r = multiplier − 2^k cycles. Done is high in the cycle that follows the (k+r)-th rising edge after the edge that accepted start. The edge that accepts start counts as edge 0.
- R4: A multiplier of zero skips both phases. Done rises immediately after the accepting edge, with a product of zero. A multiplier of one also has zero latency and returns the multiplicand.
- R5: Done stays high for exactly one cycle, and the block then returns to idle.
- R6: Start is ignored while a multiplication is running and during the done cycle. Changes to the operand inputs in those cycles do not alter the result.
- R7: The product output changes only in the cycle in which done rises, and it holds its value otherwise.
- R8: After a synchronous active-high reset, done is low, the product is zero, and the block is idle and accepts a start pulse.
- R9: 24 × 12 gives 288 after 7 cycles (k=3, r=4). 31 × 22 gives 682 after 10 cycles (k=4, r=6).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start strobe, sampled only while idle |
| mcand_i | input | 5 | Unsigned multiplicand |
| mplier_i | input | 5 | Unsigned multiplier |
| product_o | output | 10 | Registered product |
| done_o | output | 1 | One-cycle result-valid flag |

## Verification
Several properties are checked on every cycle:
- the product is correct whenever done is high;
- done never lasts two cycles;
- the product holds between done pulses;
- the captured operands stay frozen while the run is busy;
- the shared counter never underflows;
- the leading-one decoder always gives an exponent and remainder that are consistent with each other.

The exact latency of k+r cycles, the zero-multiplier shortcut and the rejection of start strobes during a run are shown only by the bench. It times every one of the 1024 operand pairs plus random runs, and it pulses start and changes the operands in the middle of many of those runs.

// File: rtl/psam_pkg.sv
package psam_pkg;
  typedef enum logic [1:0] {
    S_IDLE  = 2'd0,
    S_SHIFT = 2'd1,
    S_ADD   = 2'd2,
    S_DONE  = 2'd3
  } psam_state_t;
endpackage

// File: rtl/psam_lead_one.sv
module psam_lead_one #(
  parameter int W  = 5,
  parameter int KW = $clog2(W)
) (
  input  logic [W-1:0]  m_i,
  output logic [KW-1:0] k_o,
  output logic [W-1:0]  r_o
);
  logic [KW-1:0] kk;

  always_comb begin
    kk = '0;
    for (int i = 0; i < W; i++) begin
      if (m_i[i]) kk = i[KW-1:0];
    end
  end

  assign k_o = kk;
  // clearing the leading one leaves m - 2^k
  assign r_o = (m_i == '0) ? '0 : (m_i ^ (W'(1) << kk));

  always_comb begin
    if (m_i != '0) begin
      a_r2_leading_bit: assert ((m_i >> k_o) == W'(1));
      a_r3_remainder_below: assert (r_o < (W'(1) << k_o));
    end
  end
endmodule

// File: rtl/psam_step_counter.sv
module psam_step_counter #(
  parameter int CW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load_i,
  input  logic [CW-1:0] load_val_i,
  input  logic          dec_i,
  output logic [CW-1:0] value_o,
  output logic          last_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)         cnt_q <= '0;
    else if (load_i) cnt_q <= load_val_i;
    else if (dec_i)  cnt_q <= cnt_q - CW'(1);
  end

  assign value_o = cnt_q;
  assign last_o  = (cnt_q == CW'(1));

  a_r2_no_underflow: assert property (@(posedge clk) disable iff (rst)
    (dec_i && !load_i) |-> (cnt_q != '0));
endmodule

// File: rtl/pow2_shift_add_mul.sv
module pow2_shift_add_mul
  import psam_pkg::*;
#(
  parameter int W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic [W-1:0]     mcand_i,
  input  logic [W-1:0]     mplier_i,
  output logic [2*W-1:0]   product_o,
  output logic             done_o
);
  localparam int PW = 2 * W;
  localparam int KW = $clog2(W);

  psam_state_t   state_q, state_d;
  logic [W-1:0]  mcand_q, mplier_q, rem_q;
  logic [PW-1:0] acc_q, acc_shl, acc_sum, prod_q, prod_val;
  logic          prod_load, done_q;
  logic [KW-1:0] k_w;
  logic [W-1:0]  r_w;
  logic          cnt_load, cnt_dec, cnt_last;
  logic [W-1:0]  cnt_val, cnt_value;

  psam_lead_one #(.W(W), .KW(KW)) u_lead (
    .m_i(mplier_i), .k_o(k_w), .r_o(r_w)
  );

  psam_step_counter #(.CW(W)) u_cnt (
    .clk(clk), .rst(rst), .load_i(cnt_load), .load_val_i(cnt_val),
    .dec_i(cnt_dec), .value_o(cnt_value), .last_o(cnt_last)
  );

  assign acc_shl = {acc_q[PW-2:0], 1'b0};
  assign acc_sum = acc_q + PW'(mcand_q);

  always_comb begin
    state_d   = state_q;
    cnt_load  = 1'b0;
    cnt_val   = '0;
    cnt_dec   = 1'b0;
    prod_load = 1'b0;
    prod_val  = acc_q;
    unique case (state_q)
      S_IDLE: if (start_i) begin
        cnt_load = 1'b1;
        if (mplier_i == '0) begin
          state_d = S_DONE; prod_load = 1'b1; prod_val = '0;
        end else if (k_w != '0) begin
          state_d = S_SHIFT; cnt_val = W'(k_w);
        end else if (r_w != '0) begin
          state_d = S_ADD; cnt_val = r_w;
        end else begin
          state_d = S_DONE; prod_load = 1'b1; prod_val = PW'(mcand_i);
        end
      end
      S_SHIFT: begin
        cnt_dec = 1'b1;
        if (cnt_last) begin
          if (rem_q != '0) begin
            state_d = S_ADD; cnt_load = 1'b1; cnt_val = rem_q;
          end else begin
            state_d = S_DONE; prod_load = 1'b1; prod_val = acc_shl;
          end
        end
      end
      S_ADD: begin
        cnt_dec = 1'b1;
        if (cnt_last) begin
          state_d = S_DONE; prod_load = 1'b1; prod_val = acc_sum;
        end
      end
      S_DONE: state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= S_IDLE;
      mcand_q  <= '0;
      mplier_q <= '0;
      rem_q    <= '0;
      acc_q    <= '0;
      prod_q   <= '0;
      done_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= (state_d == S_DONE);
      if (prod_load) prod_q <= prod_val;
      unique case (state_q)
        S_IDLE: if (start_i) begin
          mcand_q  <= mcand_i;
          mplier_q <= mplier_i;
          rem_q    <= r_w;
          acc_q    <= PW'(mcand_i);
        end
        S_SHIFT: acc_q <= acc_shl;
        S_ADD:   acc_q <= acc_sum;
        default: ;
      endcase
    end
  end

  assign product_o = prod_q;
  assign done_o    = done_q;

  a_r1_product_exact: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (product_o == PW'(mcand_q) * PW'(mplier_q)));
  a_r5_done_single: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);
  a_r7_product_hold: assert property (@(posedge clk) disable iff (rst)
    !$rose(done_o) |-> $stable(product_o));
  a_r6_operands_frozen: assert property (@(posedge clk) disable iff (rst)
    (state_q == S_SHIFT || state_q == S_ADD) |=> ($stable(mcand_q) && $stable(mplier_q)));
  a_r3_add_count_live: assert property (@(posedge clk) disable iff (rst)
    (state_q == S_ADD) |-> (cnt_value != '0));
endmodule

// File: tb/sim_pow2_shift_add_mul.sv
module sim_pow2_shift_add_mul;
  localparam int W  = 5;
  localparam int PW = 2 * W;
  localparam time TCK = 8ns;

  logic clk = 1'b0, rst = 1'b1, start = 1'b0;
  logic [W-1:0] mcand = '0, mplier = '0;
  logic [PW-1:0] product;
  logic done;
  int checks = 0, errors = 0;
  bit finished = 0;

  always #(TCK/2) clk = ~clk;

  pow2_shift_add_mul #(.W(W)) u0 (
    .clk(clk), .rst(rst), .start_i(start), .mcand_i(mcand),
    .mplier_i(mplier), .product_o(product), .done_o(done)
  );

  function automatic int exp_latency(int b);
    int k = 0;
    if (b == 0) return 0;
    while ((2 << k) <= b) k++;
    return k + (b - (1 << k));
  endfunction

  task automatic check(string req, int act, int expv);
    checks++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic run(int a, int b, bit meddle, string req);
    int n = 0;
    logic [PW-1:0] held;
    @(negedge clk);
    mcand = W'(a); mplier = W'(b); start = 1'b1;
    @(posedge clk); @(negedge clk);
    start = 1'b0;
    if (meddle) begin mcand = ~W'(a); mplier = ~W'(b); end
    while (!done && n < 100) begin
      start = meddle;   // R6: strobes during a run must be ignored
      @(posedge clk); @(negedge clk);
      n++;
    end
    start = 1'b0;
    check({req, " R3 latency"}, n, exp_latency(b));
    check({req, " R1 product"}, int'(product), a * b);
    held = product;
    @(negedge clk);
    check("R5 done single cycle", int'(done), 0);
    check("R7 product holds", int'(product), int'(held));
  endtask

  initial begin
    #(TCK * 200000);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    check("R8 reset done", int'(done), 0);
    check("R8 reset product", int'(product), 0);
    // R9 directed examples
    run(24, 12, 1'b0, "R9");
    run(31, 22, 1'b1, "R9");
    // R4 zero and one multiplier, R2 long shift phase
    run(17, 0, 1'b1, "R4");
    run(29, 1, 1'b0, "R4");
    run(31, 31, 1'b1, "R2");
    run(31, 16, 1'b0, "R2");
    // exhaustive pairs, meddling with operands in a third of runs (R6)
    for (int a = 0; a < 32; a++)
      for (int b = 0; b < 32; b++)
        run(a, b, ((a + b) % 3) == 0, "R6");
    for (int i = 0; i < 200; i++)
      run(int'($urandom_range(31)), int'($urandom_range(31)), $urandom_range(1) == 1, "R1");
    finished = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule